// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer Bank

This block holds a bank of identical timers. Each timer has one bidirectional pin and runs in one of three modes. In waveform mode it drives a pulse train of programmable period and high time. In capture mode it samples the pin and measures the high time and the full period of an incoming signal. In event-watchdog mode it counts edges on the pin and raises an interrupt when a programmed number of edges has arrived. Each timer holds four registers: a 6-bit setup word, a count, a period and a width. Software writes them through one write port and reads them back through a separate read selector.

A register shared by the whole bank holds one enable bit per timer, with separate set and clear strobes. It also holds one sticky overflow flag per timer, which software clears by writing one to it. The pin direction is a separate output-enable signal per timer. The pin input passes through a two-flop synchroniser before edge detection. Each timer drives a one-cycle interrupt pulse. Clock prescaling and interrupt routing belong to the surrounding logic.

Top module: `gp_timer_bank`

## Requirements
- R1: After reset all enables, overflow flags, interrupts, output enables and pin outputs are 0, and every timer's setup, count, period and width read back as 0.
- R2: A one on `en_set[i]` enables timer i on the next edge and a one on `en_clr[i]` disables it, independently per timer. Clear wins when both strike together.
- R3: Setup bits [1:0] select the mode (0 idle, 1 waveform, 2 capture, 3 event watchdog). `pin_oe[i]` is 1 exactly when timer i is in waveform mode, and `pin_out[i]` is 0 in the other modes.
- R4: In waveform mode an enabled timer's count steps by one each cycle and returns to 1 after reaching PERIOD. The pin is high while 1 ≤ count ≤ WIDTH. Setup bit 4 inverts the pin.
- R5: Setup bit 2 enables interrupts. In waveform mode `irq[i]` pulses for one cycle, in the cycle after the count equals a nonzero PERIOD. With bit 2 clear, `irq[i]` stays 0.
- R6: In capture mode the first rising edge arms the timer and restarts the count. Each falling edge loads WIDTH with the cycles spent high. Each later rising edge loads PERIOD with the cycles since the previous rising edge and pulses `irq[i]` on the next cycle.
- R7: The pin input is synchronised by two flops before edge detection. Captured WIDTH and PERIOD equal the pin's true high time and period in clock cycles.
- R8: When the capture count wraps past its maximum, `ovf_flag[i]` is set and stays set until a one on `ovf_clr[i]`. A new overflow in the same cycle wins over the clear.
- R9: In event-watchdog mode each edge of the selected polarity raises the count by one (setup bit 3: 0 rising, 1 falling). When the count reaches PERIOD it returns to 0 and `irq[i]` pulses on the next cycle.
- R10: A disabled timer holds its count, raises no interrupt, keeps its pin output inactive and drops any capture arming.
- R11: With `reg_wr` high, `reg_sel` picks the target register of timer `reg_idx` (0 setup, 1 count, 2 period, 3 width). The write takes effect on the next edge and takes priority over the timer's own update.
- R12: `rd_cfg`, `rd_count`, `rd_period` and `rd_width` show the registers of timer `rd_idx` without delay. They read as 0 when the index is out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Timer targeted by the write |
| reg_sel | input | 2 | Register targeted by the write |
| reg_wdata | input | COUNT_W | Write data (setup uses the low 6 bits) |
| en_set | input | N_TIMERS | Per-timer enable set strobes |
| en_clr | input | N_TIMERS | Per-timer enable clear strobes |
| ovf_clr | input | N_TIMERS | Per-timer overflow flag clear (write one) |
| pin_in | input | N_TIMERS | Input side of each timer pin |
| pin_out | output | N_TIMERS | Output side of each timer pin |
| pin_oe | output | N_TIMERS | Pin output enable |
| irq | output | N_TIMERS | One-cycle interrupt pulses |
| tmr_enabled | output | N_TIMERS | Enable bits of the shared register |
| ovf_flag | output | N_TIMERS | Sticky overflow flags |
| rd_idx | input | IDX_W | Timer selected for read-back |
| rd_cfg | output | 6 | Setup word of the selected timer |
| rd_count | output | COUNT_W | Count of the selected timer |
| rd_period | output | COUNT_W | Period register of the selected timer |
| rd_width | output | COUNT_W | Width register of the selected timer |

## Verification
The bench builds the bank with three timers and an 8-bit counter. This lets one run place a timer in each mode at the same time. It also makes a capture overflow reachable within about 260 cycles of steady high input, so the sticky flag and its clear are exercised. Two bits of read index leave code 3 unused, which tests the out-of-range read-back.

// File: rtl/gpt_pkg.sv
// Shared types and field positions for the general-purpose timer bank.
package gpt_pkg;
    localparam int CFG_W       = 6;
    localparam int CFG_IRQ_EN  = 2;
    localparam int CFG_EV_FALL = 3;
    localparam int CFG_INV     = 4;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_WAVE = 2'd1,
        MODE_CAPT = 2'd2,
        MODE_EVWD = 2'd3
    } gpt_mode_e;

    typedef enum logic [1:0] {
        SEL_CFG    = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_WIDTH  = 2'd3
    } gpt_sel_e;
endpackage

// File: rtl/gpt_pin_sync.sv
// Two-flop synchroniser plus edge detector for one timer pin.
// Assumes pin_raw is asynchronous to clk; rise/fall are single-cycle.
module gpt_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic rise,
    output logic fall
);
    // stage[0] meta flop, stage[1] synchronised level, stage[2] previous level
    logic [2:0] stage_q;

    // Shift the raw pin through the synchroniser and history flop
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= {stage_q[1:0], pin_raw};
    end

    assign rise = stage_q[1] & ~stage_q[2];
    assign fall = ~stage_q[1] & stage_q[2];
endmodule

// File: rtl/gpt_ctl.sv
// Shared control/status register: per-timer enable bits and sticky
// overflow flags. Assumes strobes are one-cycle pulses from software.
module gpt_ctl #(
    parameter int N_TIMERS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_TIMERS-1:0] en_set,
    input  logic [N_TIMERS-1:0] en_clr,
    input  logic [N_TIMERS-1:0] ovf_evt,
    input  logic [N_TIMERS-1:0] ovf_clr,
    output logic [N_TIMERS-1:0] en_q,
    output logic [N_TIMERS-1:0] ovf_q
);
    // Enable bits: clear beats set; overflow flags: new event beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            ovf_q <= '0;
        end else begin
            en_q  <= (en_q | en_set) & ~en_clr;
            ovf_q <= (ovf_q & ~ovf_clr) | ovf_evt;
        end
    end

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_chk
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) // R8
            (ovf_q[i] && !ovf_clr[i]) |=> ovf_q[i]);
        AST_EN_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) // R2
            en_clr[i] |=> !en_q[i]);
    end
endmodule

// File: rtl/gpt_core.sv
// One timer channel: setup/count/period/width registers and the mode
// engine for waveform, capture and event-watchdog operation.
// Assumes rise/fall come from a synchroniser and en from the shared register.
module gpt_core
    import gpt_pkg::*;
#(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               wr_cfg,
    input  logic               wr_count,
    input  logic               wr_period,
    input  logic               wr_width,
    input  logic [COUNT_W-1:0] wdata,
    input  logic               rise,
    input  logic               fall,
    output logic [CFG_W-1:0]   cfg_q,
    output logic [COUNT_W-1:0] cnt_q,
    output logic [COUNT_W-1:0] period_q,
    output logic [COUNT_W-1:0] width_q,
    output logic               pin_out,
    output logic               pin_oe,
    output logic               irq,
    output logic               ovf_evt
);
    localparam logic [COUNT_W-1:0] ONE     = COUNT_W'(1);
    localparam logic [COUNT_W-1:0] CNT_MAX = '1;

    gpt_mode_e          mode;
    logic               armed_q, armed_d;
    logic [COUNT_W-1:0] cnt_d, period_d, width_d;
    logic               evt, ovf_d, ev_edge, irq_q;

    assign mode    = gpt_mode_e'(cfg_q[1:0]);
    assign ev_edge = cfg_q[CFG_EV_FALL] ? fall : rise;

    // Next-state of the mode engine, with software writes taking priority
    always_comb begin
        cnt_d    = cnt_q;
        period_d = period_q;
        width_d  = width_q;
        armed_d  = armed_q;
        evt      = 1'b0;
        ovf_d    = 1'b0;
        if (!en || mode != MODE_CAPT) armed_d = 1'b0;
        if (en) begin
            case (mode)
                MODE_WAVE: begin
                    cnt_d = (cnt_q >= period_q) ? ONE : cnt_q + ONE;
                    evt   = (cnt_q == period_q) && (period_q != '0);
                end
                MODE_CAPT: begin
                    if (rise) begin
                        if (armed_q) begin
                            period_d = cnt_q;
                            evt      = 1'b1;
                        end
                        armed_d = 1'b1;
                        cnt_d   = ONE;
                    end else if (armed_q) begin
                        if (fall) width_d = cnt_q;
                        ovf_d = (cnt_q == CNT_MAX);
                        cnt_d = cnt_q + ONE;
                    end
                end
                MODE_EVWD: begin
                    if (ev_edge) begin
                        if (cnt_q + ONE == period_q) begin
                            cnt_d = '0;
                            evt   = 1'b1;
                        end else begin
                            cnt_d = cnt_q + ONE;
                        end
                    end
                end
                MODE_OFF: ;
                default: ;
            endcase
        end
        if (wr_count)  cnt_d    = wdata;
        if (wr_period) period_d = wdata;
        if (wr_width)  width_d  = wdata;
    end

    // Register the channel state and the gated interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            cnt_q    <= '0;
            period_q <= '0;
            width_q  <= '0;
            armed_q  <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (wr_cfg) cfg_q <= wdata[CFG_W-1:0];
            cnt_q    <= cnt_d;
            period_q <= period_d;
            width_q  <= width_d;
            armed_q  <= armed_d;
            irq_q    <= en & cfg_q[CFG_IRQ_EN] & evt;
        end
    end

    assign irq     = irq_q;
    assign ovf_evt = ovf_d;
    assign pin_oe  = (mode == MODE_WAVE);
    assign pin_out = pin_oe &
                     ((en && cnt_q != '0 && cnt_q <= width_q) ^ cfg_q[CFG_INV]);

    AST_WAVE_STEP: assert property (@(posedge clk) disable iff (!rst_n) // R4
        (en && mode == MODE_WAVE && cnt_q < period_q && !wr_count)
        |=> (cnt_q == $past(cnt_q) + ONE));
    AST_WAVE_WRAP: assert property (@(posedge clk) disable iff (!rst_n) // R4
        (en && mode == MODE_WAVE && cnt_q >= period_q && !wr_count) |=> (cnt_q == ONE));
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) // R5
        (!cfg_q[CFG_IRQ_EN] || !en) |=> !irq);
    AST_CAPT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (en && mode == MODE_CAPT && armed_q && fall && !wr_width)
        |=> (width_q == $past(cnt_q)));
    AST_CAPT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) // R6
        (en && mode == MODE_CAPT && armed_q && rise && !wr_period)
        |=> (period_q == $past(cnt_q)));
    AST_EVWD_IRQ: assert property (@(posedge clk) disable iff (!rst_n) // R9
        (en && mode == MODE_EVWD && cfg_q[CFG_IRQ_EN] && ev_edge && (cnt_q + ONE == period_q))
        |=> irq);
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n) // R10
        (!en && !wr_count) |=> $stable(cnt_q));
endmodule

// File: rtl/gp_timer_bank.sv
// Bank of general-purpose timers sharing one enable/status register.
// Assumes COUNT_W >= 6 (the setup word comes from the low write bits).
module gp_timer_bank
    import gpt_pkg::*;
#(
    parameter int N_TIMERS = 3,
    parameter int COUNT_W  = 32,
    localparam int IDX_W   = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic [1:0]          reg_sel,
    input  logic [COUNT_W-1:0]  reg_wdata,
    input  logic [N_TIMERS-1:0] en_set,
    input  logic [N_TIMERS-1:0] en_clr,
    input  logic [N_TIMERS-1:0] ovf_clr,
    input  logic [N_TIMERS-1:0] pin_in,
    output logic [N_TIMERS-1:0] pin_out,
    output logic [N_TIMERS-1:0] pin_oe,
    output logic [N_TIMERS-1:0] irq,
    output logic [N_TIMERS-1:0] tmr_enabled,
    output logic [N_TIMERS-1:0] ovf_flag,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [CFG_W-1:0]    rd_cfg,
    output logic [COUNT_W-1:0]  rd_count,
    output logic [COUNT_W-1:0]  rd_period,
    output logic [COUNT_W-1:0]  rd_width
);
    logic [N_TIMERS-1:0] ovf_evt;
    logic [CFG_W-1:0]    cfg_a    [N_TIMERS];
    logic [COUNT_W-1:0]  cnt_a    [N_TIMERS];
    logic [COUNT_W-1:0]  period_a [N_TIMERS];
    logic [COUNT_W-1:0]  width_a  [N_TIMERS];

    gpt_ctl #(.N_TIMERS(N_TIMERS)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_set  (en_set),
        .en_clr  (en_clr),
        .ovf_evt (ovf_evt),
        .ovf_clr (ovf_clr),
        .en_q    (tmr_enabled),
        .ovf_q   (ovf_flag)
    );

    for (genvar i = 0; i < N_TIMERS; i++) begin : g_tmr
        logic hit, rise, fall;
        assign hit = reg_wr && (reg_idx == IDX_W'(i));

        gpt_pin_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_raw (pin_in[i]),
            .rise    (rise),
            .fall    (fall)
        );

        gpt_core #(.COUNT_W(COUNT_W)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (tmr_enabled[i]),
            .wr_cfg    (hit && reg_sel == SEL_CFG),
            .wr_count  (hit && reg_sel == SEL_COUNT),
            .wr_period (hit && reg_sel == SEL_PERIOD),
            .wr_width  (hit && reg_sel == SEL_WIDTH),
            .wdata     (reg_wdata),
            .rise      (rise),
            .fall      (fall),
            .cfg_q     (cfg_a[i]),
            .cnt_q     (cnt_a[i]),
            .period_q  (period_a[i]),
            .width_q   (width_a[i]),
            .pin_out   (pin_out[i]),
            .pin_oe    (pin_oe[i]),
            .irq       (irq[i]),
            .ovf_evt   (ovf_evt[i])
        );
    end

    // Read-back multiplexer; out-of-range index reads zero
    always_comb begin
        rd_cfg    = '0;
        rd_count  = '0;
        rd_period = '0;
        rd_width  = '0;
        for (int i = 0; i < N_TIMERS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_cfg    = cfg_a[i];
                rd_count  = cnt_a[i];
                rd_period = period_a[i];
                rd_width  = width_a[i];
            end
        end
    end
endmodule

// File: tb/gp_timer_bank_tb.sv
module gp_timer_bank_tb;
    localparam int NT   = 3;
    localparam int CW   = 8;
    localparam int IW   = 2;
    localparam int MASK = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [IW-1:0] reg_idx = '0;
    logic [1:0]    reg_sel = '0;
    logic [CW-1:0] reg_wdata = '0;
    logic [NT-1:0] en_set = '0, en_clr = '0, ovf_clr = '0, pin_in = '0;
    logic [NT-1:0] pin_out, pin_oe, irq, tmr_enabled, ovf_flag;
    logic [IW-1:0] rd_idx = '0;
    logic [5:0]    rd_cfg;
    logic [CW-1:0] rd_count, rd_period, rd_width;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    gp_timer_bank #(.N_TIMERS(NT), .COUNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .en_set(en_set),
        .en_clr(en_clr), .ovf_clr(ovf_clr), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
        .tmr_enabled(tmr_enabled), .ovf_flag(ovf_flag), .rd_idx(rd_idx),
        .rd_cfg(rd_cfg), .rd_count(rd_count), .rd_period(rd_period),
        .rd_width(rd_width)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model state
    int m_cfg[NT], m_cnt[NT], m_per[NT], m_wid[NT];
    bit m_arm[NT], m_irq[NT], m_en[NT], m_ovf[NT];
    bit m_s0[NT], m_s1[NT], m_s2[NT];
    int irq_total[NT], hi_total[NT];
    int x_mode, nc, np, nw, ev, ov;
    bit x_rise, x_fall, x_edge, na, x_oe, x_out;

    always @(posedge clk) begin
        for (int t = 0; t < NT; t++) begin
            if (!rst_n) begin
                m_cfg[t] = 0; m_cnt[t] = 0; m_per[t] = 0; m_wid[t] = 0;
                m_arm[t] = 0; m_irq[t] = 0; m_en[t] = 0; m_ovf[t] = 0;
                m_s0[t] = 0; m_s1[t] = 0; m_s2[t] = 0;
                irq_total[t] = 0; hi_total[t] = 0;
            end else begin
                x_mode = m_cfg[t] & 3;
                x_rise = m_s1[t] && !m_s2[t];
                x_fall = !m_s1[t] && m_s2[t];
                x_edge = ((m_cfg[t] >> 3) & 1) != 0 ? x_fall : x_rise;
                nc = m_cnt[t]; np = m_per[t]; nw = m_wid[t]; na = m_arm[t];
                ev = 0; ov = 0;
                if (!m_en[t] || x_mode != 2) na = 0;
                if (m_en[t]) begin
                    if (x_mode == 1) begin
                        nc = (m_cnt[t] >= m_per[t]) ? 1 : (m_cnt[t] + 1) & MASK;
                        ev = (m_cnt[t] == m_per[t] && m_per[t] != 0) ? 1 : 0;
                    end else if (x_mode == 2) begin
                        if (x_rise) begin
                            if (m_arm[t]) begin np = m_cnt[t]; ev = 1; end
                            na = 1; nc = 1;
                        end else if (m_arm[t]) begin
                            if (x_fall) nw = m_cnt[t];
                            if (m_cnt[t] == MASK) ov = 1;
                            nc = (m_cnt[t] + 1) & MASK;
                        end
                    end else if (x_mode == 3) begin
                        if (x_edge) begin
                            if (((m_cnt[t] + 1) & MASK) == m_per[t]) begin nc = 0; ev = 1; end
                            else nc = (m_cnt[t] + 1) & MASK;
                        end
                    end
                end
                if (reg_wr && int'(reg_idx) == t) begin
                    if (reg_sel == 1) nc = int'(reg_wdata);
                    if (reg_sel == 2) np = int'(reg_wdata);
                    if (reg_sel == 3) nw = int'(reg_wdata);
                end
                m_irq[t] = m_en[t] && (((m_cfg[t] >> 2) & 1) != 0) && ev != 0;
                m_ovf[t] = (m_ovf[t] && !ovf_clr[t]) || ov != 0;
                m_en[t]  = (m_en[t] || en_set[t]) && !en_clr[t];
                m_s2[t] = m_s1[t]; m_s1[t] = m_s0[t]; m_s0[t] = pin_in[t];
                m_cnt[t] = nc; m_per[t] = np; m_wid[t] = nw; m_arm[t] = na;
                if (reg_wr && int'(reg_idx) == t && reg_sel == 0) m_cfg[t] = int'(reg_wdata) & 63;
            end
        end
        #1;
        for (int t = 0; t < NT; t++) begin
            x_oe  = (m_cfg[t] & 3) == 1;
            x_out = x_oe && ((m_en[t] && m_cnt[t] != 0 && m_cnt[t] <= m_wid[t]) ^ (((m_cfg[t] >> 4) & 1) != 0));
            check("R2 enable", int'(tmr_enabled[t]), int'(m_en[t]));
            check("R3 pin_oe", int'(pin_oe[t]), int'(x_oe));
            check("R4 pin_out", int'(pin_out[t]), int'(x_out));
            check("R5 irq", int'(irq[t]), int'(m_irq[t]));
            check("R8 ovf_flag", int'(ovf_flag[t]), int'(m_ovf[t]));
            if (rst_n) begin
                irq_total[t] += int'(irq[t]);
                hi_total[t]  += int'(pin_out[t]);
            end
        end
        if (int'(rd_idx) < NT) begin
            check("R12 rd_cfg", int'(rd_cfg), m_cfg[rd_idx]);
            check("R11 rd_count", int'(rd_count), m_cnt[rd_idx]);
            check("R6 rd_period", int'(rd_period), m_per[rd_idx]);
            check("R6 rd_width", int'(rd_width), m_wid[rd_idx]);
        end
    end

    task automatic wr(input int idx, input int sel, input int data);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = IW'(idx); reg_sel = 2'(sel); reg_wdata = CW'(data);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic strobe_en(input logic [NT-1:0] s, input logic [NT-1:0] c);
        @(negedge clk);
        en_set = s; en_clr = c;
        @(negedge clk);
        en_set = '0; en_clr = '0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    int a, b, c1;

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        check("R1 enables", int'(tmr_enabled), 0);
        check("R1 pin_oe", int'(pin_oe), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 rd_count", int'(rd_count), 0);

        // Waveform on timer 0: period 5, width 2, irq enabled
        wr(0, 0, 5); wr(0, 2, 5); wr(0, 3, 2);
        strobe_en(3'b001, 3'b000);
        wait_cyc(12);
        a = irq_total[0]; b = hi_total[0];
        wait_cyc(10);
        check("R5 irq per window", irq_total[0] - a, 2);
        check("R4 high per window", hi_total[0] - b, 4);
        check("R3 oe waveform", int'(pin_oe[0]), 1);
        // R4 inverted output
        wr(0, 0, 5 | 16);
        wait_cyc(6);
        b = hi_total[0];
        wait_cyc(10);
        check("R4 inverted high", hi_total[0] - b, 6);
        wr(0, 0, 1);
        wait_cyc(6);
        a = irq_total[0];
        wait_cyc(10);
        check("R5 irq masked", irq_total[0] - a, 0);
        wr(0, 0, 5);
        // R11 count write priority while running
        wr(0, 1, 3);
        check("R11 count write", int'(rd_count), 3);

        // Capture on timer 1: high 5, low 7
        wr(1, 0, 6);
        strobe_en(3'b010, 3'b000);
        wait_cyc(5);
        check("R3 oe capture", int'(pin_oe[1]), 0);
        a = irq_total[1];
        for (int k = 0; k < 3; k++) begin
            pin_in[1] = 1'b1; wait_cyc(5);
            pin_in[1] = 1'b0; wait_cyc(7);
        end
        wait_cyc(5);
        rd_idx = 2'd1;
        wait_cyc(1);
        check("R6 capture irqs", irq_total[1] - a, 2);
        check("R7 width cycles", int'(rd_width), 5);
        check("R7 period cycles", int'(rd_period), 12);
        // R8 overflow while held high
        pin_in[1] = 1'b1; wait_cyc(300);
        pin_in[1] = 1'b0; wait_cyc(3);
        check("R8 overflow set", int'(ovf_flag[1]), 1);
        wait_cyc(5);
        check("R8 overflow held", int'(ovf_flag[1]), 1);
        @(negedge clk); ovf_clr = 3'b010;
        @(negedge clk); ovf_clr = '0;
        check("R8 overflow cleared", int'(ovf_flag[1]), 0);

        // Event watchdog on timer 2: falling edges, period 4
        wr(2, 0, 15); wr(2, 2, 4);
        strobe_en(3'b100, 3'b000);
        wait_cyc(3);
        a = irq_total[2];
        for (int k = 0; k < 8; k++) begin
            pin_in[2] = 1'b1; wait_cyc(2);
            pin_in[2] = 1'b0; wait_cyc(2);
        end
        wait_cyc(5);
        rd_idx = 2'd2;
        wait_cyc(1);
        check("R9 watchdog irqs", irq_total[2] - a, 2);
        check("R9 watchdog count", int'(rd_count), 0);
        check("R3 oe watchdog", int'(pin_oe[2]), 0);

        // R10 disabled timer holds
        strobe_en(3'b000, 3'b001);
        rd_idx = 2'd0;
        wait_cyc(2);
        c1 = int'(rd_count); a = irq_total[0];
        wait_cyc(10);
        check("R10 count held", int'(rd_count), c1);
        check("R10 no irq", irq_total[0] - a, 0);
        check("R10 pin idle", int'(pin_out[0]), 0);

        // R2 simultaneous set/clear
        strobe_en(3'b000, 3'b111);
        strobe_en(3'b101, 3'b100);
        check("R2 clear wins", int'(tmr_enabled), 1);

        // R12 out-of-range read index
        rd_idx = 2'd3;
        wait_cyc(1);
        check("R12 oor cfg", int'(rd_cfg), 0);
        check("R12 oor count", int'(rd_count), 0);
        check("R12 oor period", int'(rd_period), 0);
        check("R12 oor width", int'(rd_width), 0);
        wait_cyc(4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule